// File: doc/BRIEF.md
# Chainable Serial Data Output for a Serial-Loaded Converter

This block is the shift-register side of a serial converter interface. It samples chip select, serial clock and serial data with the system clock and shifts each bit in on a rising serial-clock edge while chip select is low. It drives the bit leaving the far end of the register onto a serial output pin. Several devices can share one clock line and one chip-select line, with each output wired to the next data input. Each frame then pushes the previous frame's word one device further down the chain. The same path lets a host read back what a register holds.

The edge that launches the output is set by a mode input, which the command decoder drives. With the mode low, the output changes on the rising serial-clock edge. With it high, the change waits for the falling edge that follows, which is half a serial-clock period later. The bit that arrives at the next device's sampling edge is the same in both modes. While the shutdown input is high the output pin is frozen, but shifting and word capture go on. When chip select rises, the register contents are handed to the decoder as a parallel word.

Top module: `chain_dout`

## Requirements
- R1: After reset, dout is 0, the shift register holds all zeros and wordOut is 0.
- R2: Each rising sclk edge while csN is low shifts din into bit 0 and moves every other bit one place up. When csN rises, wordOut takes the register contents, so the first of the last 16 bits shifted lands in bit 15.
- R3: With halfMode = 0, dout changes only on a rising sclk edge and takes the bit that becomes the register's top bit. Counting rising edges from 1 in a window, dout during the low phase before edge m and during the high phase after it equals bit m-16 and bit m-15 respectively.
- R4: With halfMode = 1, dout changes only on a falling sclk edge and takes the register's top bit. During the high phase after rising edge m it still shows bit m-16, and after the falling edge it shows bit m-15.
- R5: While csN is high, sclk edges are ignored: the register does not shift and dout holds its value.
- R6: While shdn is high, dout holds its value. The register keeps shifting and wordOut keeps capturing.
- R7: In a chain of n devices that share csN and sclk, n frames written in turn leave the i-th frame in device n-i+1 (device 1 is the one fed by the host).
- R8: wordOut changes only when csN rises; it is stable throughout a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idle low |
| din | input | 1 | Serial data in, sampled on rising sclk |
| halfMode | input | 1 | Launch edge select: 0 rising, 1 falling |
| shdn | input | 1 | Shutdown; freezes dout while high |
| dout | output | 1 | Serial data out toward the next device |
| wordOut | output | WORD_BITS | Register contents captured at csN rise |

## Verification
The bench builds three instances with the default 16-bit word and a two-stage synchronizer and chains them output to input. Frames written one after another must therefore come to rest one device apart. Long chip-select windows of 40 bits in each launch mode check the output bit by bit against an arithmetic data pattern in both clock phases, which separates the rising-edge and falling-edge launch. Further runs with chip select high and with shutdown asserted show, through the words captured downstream, whether the register or the output moved.

// File: rtl/chain_dout_pkg.sv
package chain_dout_pkg;

  typedef enum logic {
    LAUNCH_RISE = 1'b0,
    LAUNCH_FALL = 1'b1
  } launchEdge_e;

  typedef struct packed {
    logic shift;     // move register one place, take new bit
    logic loadNext;  // output takes the bit about to reach the top
    logic loadMsb;   // output takes the current top bit
    logic capture;   // hand register contents to the word output
  } ctlStrobes_t;

endpackage

// File: rtl/chain_dout_sync.sv
module chain_dout_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= {STAGES{RESET_VAL}};
        else       stage <= asyncIn;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= {STAGES{RESET_VAL}};
        else       stage <= {stage[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/chain_dout_ctrl.sv
module chain_dout_ctrl
  import chain_dout_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csS,
  input  logic        sclkS,
  input  logic        halfMode,
  input  logic        shdn,
  output ctlStrobes_t ctl
);

  logic sclkPrev;
  logic csPrev;
  logic sclkRise;
  logic sclkFall;
  logic frameOpen;
  logic outFree;
  launchEdge_e edgeSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPrev <= sclkS;
      csPrev   <= csS;
    end
  end

  assign edgeSel   = launchEdge_e'(halfMode);
  assign sclkRise  = sclkS & ~sclkPrev;
  assign sclkFall  = ~sclkS & sclkPrev;
  assign frameOpen = ~csS;
  assign outFree   = frameOpen & ~shdn;

  always_comb begin
    ctl          = '0;
    ctl.shift    = sclkRise & frameOpen;
    ctl.capture  = csS & ~csPrev;
    unique case (edgeSel)
      LAUNCH_RISE: ctl.loadNext = sclkRise & outFree;
      LAUNCH_FALL: ctl.loadMsb  = sclkFall & outFree;
      default:     ctl.loadNext = 1'b0;
    endcase
  end

endmodule

// File: rtl/chain_dout_path.sv
module chain_dout_path
  import chain_dout_pkg::*;
#(
  parameter int WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          ctl,
  input  logic                 dinS,
  output logic                 dout,
  output logic [WORD_BITS-1:0] wordOut
);

  localparam int TOP = WORD_BITS - 1;
  localparam int NEXT = WORD_BITS - 2;

  logic [WORD_BITS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctl.shift) begin
      shiftReg <= {shiftReg[NEXT:0], dinS};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dout <= 1'b0;
    end else if (ctl.loadNext) begin
      dout <= shiftReg[NEXT];
    end else if (ctl.loadMsb) begin
      dout <= shiftReg[TOP];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordOut <= '0;
    end else if (ctl.capture) begin
      wordOut <= shiftReg;
    end
  end

endmodule

// File: rtl/chain_dout.sv
module chain_dout
  import chain_dout_pkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 sclk,
  input  logic                 din,
  input  logic                 halfMode,
  input  logic                 shdn,
  output logic                 dout,
  output logic [WORD_BITS-1:0] wordOut
);

  localparam int PIN_COUNT = 3;
  localparam logic [PIN_COUNT-1:0] IDLE_PINS = 3'b100;

  logic [PIN_COUNT-1:0] pinSync;
  logic csS;
  logic sclkS;
  logic dinS;
  ctlStrobes_t ctl;

  chain_dout_sync #(
    .WIDTH(PIN_COUNT),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(IDLE_PINS)
  ) i_sync (
    .clk(clk),
    .rstN(rstN),
    .asyncIn({csN, sclk, din}),
    .syncOut(pinSync)
  );

  assign {csS, sclkS, dinS} = pinSync;

  chain_dout_ctrl i_ctrl (
    .clk(clk),
    .rstN(rstN),
    .csS(csS),
    .sclkS(sclkS),
    .halfMode(halfMode),
    .shdn(shdn),
    .ctl(ctl)
  );

  chain_dout_path #(
    .WORD_BITS(WORD_BITS)
  ) i_path (
    .clk(clk),
    .rstN(rstN),
    .ctl(ctl),
    .dinS(dinS),
    .dout(dout),
    .wordOut(wordOut)
  );

endmodule

// File: rtl/chain_dout_chk.sv
module chain_dout_chk #(
  parameter int WORD_BITS = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 halfMode,
  input logic                 shdn,
  input logic                 csLevel,
  input logic                 shiftStb,
  input logic                 captureStb,
  input logic                 dout,
  input logic [WORD_BITS-1:0] wordOut
);

  assert_rise_launch_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(dout) && !$past(halfMode)) |-> $past(shiftStb));

  assert_fall_launch_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(dout) && $past(halfMode)) |-> !$past(shiftStb));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(csLevel) |-> $stable(dout));

  assert_shdn_freeze_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(shdn) |-> $stable(dout));

  assert_word_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(captureStb) |-> $stable(wordOut));

endmodule

bind chain_dout chain_dout_chk #(
  .WORD_BITS(WORD_BITS)
) i_chk (
  .clk(clk),
  .rstN(rstN),
  .halfMode(halfMode),
  .shdn(shdn),
  .csLevel(csS),
  .shiftStb(ctl.shift),
  .captureStb(ctl.capture),
  .dout(dout),
  .wordOut(wordOut)
);

// File: tb/test_chain_dout.sv
module test_chain_dout;

  localparam int W = 16;
  localparam int HALF = 6;
  localparam int WINDOW = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic halfMode = 1'b0;
  logic shdn = 1'b0;
  logic doutA, doutB, doutC;
  logic [W-1:0] wordA, wordB, wordC;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  chain_dout #(.WORD_BITS(W), .SYNC_STAGES(2)) i_chain_dout (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .halfMode(halfMode), .shdn(shdn), .dout(doutA), .wordOut(wordA));

  chain_dout #(.WORD_BITS(W), .SYNC_STAGES(2)) i_chain_dout_b (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(doutA),
    .halfMode(halfMode), .shdn(shdn), .dout(doutB), .wordOut(wordB));

  chain_dout #(.WORD_BITS(W), .SYNC_STAGES(2)) i_chain_dout_c (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(doutB),
    .halfMode(halfMode), .shdn(shdn), .dout(doutC), .wordOut(wordC));

  task automatic checkEq(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitHalf();
    repeat (HALF) @(negedge clk);
  endtask

  function automatic logic bitAt(input int k);
    if (k < 1) return 1'b0;
    return ((k * 13 + (k >> 3)) % 7) < 3;
  endfunction

  task automatic sendFrame(input logic [W-1:0] w);
    logic [W-1:0] held;
    held = wordA;
    csN = 1'b0;
    waitHalf();
    for (int i = W - 1; i >= 0; i--) begin
      din = w[i];
      waitHalf();
      sclk = 1'b1;
      waitHalf();
      if (i == 7) checkEq("R8 word stable mid-frame", wordA, held);
      sclk = 1'b0;
    end
    waitHalf();
    csN = 1'b1;
    waitHalf();
    waitHalf();
  endtask

  task automatic streamTest(input logic mode);
    logic expHigh;
    halfMode = mode;
    sendFrame('0);
    csN = 1'b0;
    waitHalf();
    for (int m = 1; m <= WINDOW; m++) begin
      din = bitAt(m);
      waitHalf();
      checkEq(mode ? "R4 low phase" : "R3 low phase", W'(doutA), W'(bitAt(m - 16)));
      sclk = 1'b1;
      waitHalf();
      expHigh = mode ? bitAt(m - 16) : bitAt(m - 15);
      checkEq(mode ? "R4 high phase" : "R3 high phase", W'(doutA), W'(expHigh));
      sclk = 1'b0;
    end
    waitHalf();
    csN = 1'b1;
    waitHalf();
    waitHalf();
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    logic d0;
    logic dA;
    logic [W-1:0] x, y, z;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkEq("R1 dout after reset", W'(doutA), '0);
    checkEq("R1 word after reset", wordA, '0);
    checkEq("R1 chained word after reset", wordB, '0);

    streamTest(1'b0);
    streamTest(1'b1);

    for (int mode = 0; mode < 2; mode++) begin
      halfMode = mode[0];
      for (int t = 0; t < 4; t++) begin
        logic [W-1:0] w1, w2, w3;
        w1 = W'((t * 937 + 1 * 7963) ^ 16'hA5C3);
        w2 = W'((t * 937 + 2 * 7963) ^ 16'h5A3C);
        w3 = W'((t * 937 + 3 * 7963) ^ 16'h0FF1);
        sendFrame(w1);
        checkEq("R2 captured word", wordA, w1);
        sendFrame(w2);
        checkEq("R2 captured word", wordA, w2);
        sendFrame(w3);
        checkEq("R7 device 1 holds frame 3", wordA, w3);
        checkEq("R7 device 2 holds frame 2", wordB, w2);
        checkEq("R7 device 3 holds frame 1", wordC, w1);
      end
    end

    halfMode = 1'b0;
    x = 16'hC3A5;
    y = 16'h1E6B;
    sendFrame(x);
    d0 = doutA;
    for (int p = 0; p < 5; p++) begin
      din = 1'b1;
      waitHalf();
      sclk = 1'b1;
      waitHalf();
      checkEq("R5 dout holds with csN high", W'(doutA), W'(d0));
      sclk = 1'b0;
    end
    din = 1'b0;
    sendFrame(y);
    checkEq("R5 no shift while csN high", wordB, x);
    checkEq("R5 new word in device 1", wordA, y);

    x = 16'h8421;
    y = 16'h3C5A;
    z = 16'h7E81;
    sendFrame(x);
    dA = doutA;
    checkEq("R3 dout shows top bit after frame", W'(dA), W'(x[15]));
    shdn = 1'b1;
    sendFrame(y);
    checkEq("R6 dout frozen in shutdown", W'(doutA), W'(dA));
    checkEq("R6 shifting continues in shutdown", wordA, y);
    checkEq("R6 downstream sees frozen bit", wordB, {W{dA}});
    shdn = 1'b0;
    waitHalf();
    sendFrame(z);
    checkEq("R6 capture after shutdown", wordA, z);
    checkEq("R6 output resumes after shutdown", wordB, {dA, y[14:0]});

    finishRun();
  end

endmodule